// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one 16-pin general-purpose I/O port through a small word-addressed register bus. Each pin has four settings: a mode (input, output, alternate function or analog), an output type (push-pull or open-drain), a weak pull choice, and a 4-bit selector that picks one of sixteen peripheral sources. The block drives an abstract pad model with a per-pin output value, output enable, pull-up request and pull-down request.

An output data register supplies the value of pins in output mode. In alternate-function mode, the selected peripheral's data and enable bits drive the pin instead. An input data register samples the pads on every clock and can be read back over the bus. A pin in analog mode reads as 0.

After reset most pins sit in analog mode and nothing drives them. A parameter-selected group of pins resets into alternate-function mode with source 0 and a fixed pull, so that a debug link works without any setup.

Top module: `gpio_port_ctl`

## Requirements
- R1: The block resets asynchronously when rst_n is low. Each pin has a 2-bit mode code: 00 input, 01 output, 10 alternate function, 11 analog. After reset, the pins in DBG_PINS read mode 10 and all other pins read 11. With the defaults (pins 0 to 4), the mode word is 0xFFFFFEAA. Every other reset value is as follows: pull is taken from DBG_PULL for the debug pins and 0 elsewhere (0x00000059 by default); the output type, the output data and both selector words are 0.
- R2: Register addresses on bus_addr are: 0 mode (2 bits per pin, pin i at bits 2i+1:2i), 1 output type (bit i), 2 pull (2 bits per pin), 3 output data (bit i), 4 input data (read-only), 5 selector low, 6 selector high. A pin in mode 01 with output type 0 (push-pull) drives pad_oe=1 and pad_out equal to its output data bit.
- R3: With output type 1 (open-drain), a pin drives pad_oe=1 and pad_out=0 only when its source value is 0. A source value of 1 gives pad_oe=0, so the pin is released.
- R4: The input data register loads pad_in on every rising clock edge and reads back at address 4 from the next cycle. A bus write to address 4 has no effect.
- R5: A pin in analog mode (11) loads 0 into the input data register. A pin in input or analog mode has pad_oe=0.
- R6: Pull codes: 01 asserts pad_pu, 10 asserts pad_pd, and 00 or 11 asserts neither. pad_pu and pad_pd are never both high on one pin.
- R7: In mode 10, pin i takes af_out[16*i+k] as its source value and af_oe[16*i+k] as its enable, where k is its 4-bit selector. The output type still applies. The selectors for pins 0 to 7 are at address 5, bits 4i+3:4i. The selectors for pins 8 to 15 are at address 6, bits 4(i-8)+3:4(i-8).
- R8: In modes other than 10, the selector and the peripheral inputs have no effect on pad_out or pad_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, used when bus_sel is high |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 16 | Sensed pad levels |
| pad_out | output | 16 | Pad drive value |
| pad_oe | output | 16 | Pad drive enable |
| pad_pu | output | 16 | Weak pull-up request |
| pad_pd | output | 16 | Weak pull-down request |
| af_out | input | 256 | Peripheral data, 16 sources per pin |
| af_oe | input | 256 | Peripheral enables, 16 sources per pin |

## Verification
The bench exercises open-drain pins whose source is 1. A design that drives high in that case would fight an external pull-up. It also gives each pin a distinct selector, then moves the low selector word alone. A swap of the low and high selector words, or a wrong 4-bit field offset, shows up as a wrong pad_out bit.

Analog pins are fed with pad_in held high. The bench also writes to the read-only input register. A design that lets these through shows a nonzero or corrupted input word.

Reserved pull code 11 and output-mode pins with live peripheral inputs check that neither pulls nor peripheral signals leak through.

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
  parameter logic [15:0] DBG_PINS = 16'h001F,
  parameter logic [31:0] DBG_PULL = 32'h0000_0059
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic [15:0]  pad_in,
  output logic [15:0]  pad_out,
  output logic [15:0]  pad_oe,
  output logic [15:0]  pad_pu,
  output logic [15:0]  pad_pd,
  input  logic [255:0] af_out,
  input  logic [255:0] af_oe
);
  localparam int NPIN = 16;
  localparam int NSRC = 16;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_OTYP = 3'd1;
  localparam logic [2:0] A_PULL = 3'd2;
  localparam logic [2:0] A_ODAT = 3'd3;
  localparam logic [2:0] A_IDAT = 3'd4;
  localparam logic [2:0] A_AFLO = 3'd5;
  localparam logic [2:0] A_AFHI = 3'd6;

  function automatic logic [31:0] mode_rst_f(input logic [15:0] dbg);
    logic [31:0] v;
    for (int i = 0; i < NPIN; i++) v[2*i +: 2] = dbg[i] ? 2'b10 : 2'b11;
    return v;
  endfunction

  function automatic logic [31:0] pull_rst_f(input logic [15:0] dbg, input logic [31:0] pl);
    logic [31:0] v;
    for (int i = 0; i < NPIN; i++) v[2*i +: 2] = dbg[i] ? pl[2*i +: 2] : 2'b00;
    return v;
  endfunction

  localparam logic [31:0] MODE_RST = mode_rst_f(DBG_PINS);
  localparam logic [31:0] PULL_RST = pull_rst_f(DBG_PINS, DBG_PULL);

  logic [31:0] mode_q, pull_q, aflo_q, afhi_q;
  logic [15:0] otype_q, odat_q, idat_q;
  logic [15:0] analog;
  logic [63:0] af_sel_all;

  assign af_sel_all = {afhi_q, aflo_q};
  wire wr_en = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      pull_q  <= PULL_RST;
      otype_q <= '0;
      odat_q  <= '0;
      aflo_q  <= '0;
      afhi_q  <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_MODE:  mode_q  <= bus_wdata;
        A_OTYP:  otype_q <= bus_wdata[15:0];
        A_PULL:  pull_q  <= bus_wdata;
        A_ODAT:  odat_q  <= bus_wdata[15:0];
        A_AFLO:  aflo_q  <= bus_wdata;
        A_AFHI:  afhi_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idat_q <= '0;
    else        idat_q <= pad_in & ~analog;
  end

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      logic [1:0] m;
      logic [3:0] k;
      logic       val, en;
      m   = mode_q[2*i +: 2];
      k   = af_sel_all[4*i +: 4];
      val = 1'b0;
      en  = 1'b0;
      case (m)
        2'b01: begin val = odat_q[i]; en = 1'b1; end
        2'b10: begin val = af_out[NSRC*i + int'(k)]; en = af_oe[NSRC*i + int'(k)]; end
        default: ;
      endcase
      analog[i]  = (m == 2'b11);
      pad_out[i] = otype_q[i] ? 1'b0 : val;
      pad_oe[i]  = otype_q[i] ? (en & ~val) : en;
      pad_pu[i]  = (pull_q[2*i +: 2] == 2'b01);
      pad_pd[i]  = (pull_q[2*i +: 2] == 2'b10);
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_OTYP:  bus_rdata = {16'h0, otype_q};
      A_PULL:  bus_rdata = pull_q;
      A_ODAT:  bus_rdata = {16'h0, odat_q};
      A_IDAT:  bus_rdata = {16'h0, idat_q};
      A_AFLO:  bus_rdata = aflo_q;
      A_AFHI:  bus_rdata = afhi_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] mode_q,
  input logic [15:0] otype_q,
  input logic [15:0] idat_q,
  input logic [15:0] pad_in,
  input logic [15:0] pad_out,
  input logic [15:0] pad_oe,
  input logic [15:0] pad_pu,
  input logic [15:0] pad_pd
);
  logic [15:0] is_an, is_passive, is_out;

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      is_an[i]      = mode_q[2*i +: 2] == 2'b11;
      is_passive[i] = mode_q[2*i +: 2] == 2'b11 || mode_q[2*i +: 2] == 2'b00;
      is_out[i]     = mode_q[2*i +: 2] == 2'b01;
    end
  end

  // R6
  no_dual_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == 16'h0);

  // R3
  od_release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & otype_q & pad_out) == 16'h0);

  // R5
  passive_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & is_passive) == 16'h0);

  // R2
  pushpull_out_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out & ~otype_q & ~pad_oe) == 16'h0);

  // R4
  idr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> idat_q == ($past(pad_in) & ~$past(is_an)));
endmodule

bind gpio_port_ctl gpio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .otype_q(otype_q), .idat_q(idat_q),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/tb_gpio_port_ctl.sv
module tb_gpio_port_ctl;
  localparam int CLK_P = 10;

  logic         clk = 0, rst_n = 0;
  logic         bus_sel = 0, bus_wr = 0;
  logic [2:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0, bus_rdata;
  logic [15:0]  pad_in = 16'hFFFF, pad_out, pad_oe, pad_pu, pad_pd;
  logic [255:0] af_out = '0, af_oe = '0;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  gpio_port_ctl dut (.*);

  always #(CLK_P/2) clk = ~clk;

  // reference model state
  logic [31:0] m_mode, m_pull, m_aflo, m_afhi;
  logic [15:0] m_ot, m_od, m_id;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 32'hFFFF_FEAA; m_pull <= 32'h0000_0059;
      m_aflo <= 0; m_afhi <= 0; m_ot <= 0; m_od <= 0; m_id <= 0;
    end else begin
      for (int i = 0; i < 16; i++)
        m_id[i] <= (((m_mode >> (2*i)) & 3) == 3) ? 1'b0 : pad_in[i];
      if (bus_sel && bus_wr)
        case (bus_addr)
          0: m_mode <= bus_wdata;
          1: m_ot   <= bus_wdata[15:0];
          2: m_pull <= bus_wdata;
          3: m_od   <= bus_wdata[15:0];
          5: m_aflo <= bus_wdata;
          6: m_afhi <= bus_wdata;
          default: ;
        endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_pads(output logic [15:0] o, output logic [15:0] e,
                            output logic [15:0] pu, output logic [15:0] pd);
    for (int i = 0; i < 16; i++) begin
      int m, k, pl;
      logic v, en;
      m  = (m_mode >> (2*i)) & 3;
      pl = (m_pull >> (2*i)) & 3;
      k  = (i < 8) ? ((m_aflo >> (4*i)) & 15) : ((m_afhi >> (4*(i-8))) & 15);
      v = 0; en = 0;
      if (m == 1) begin v = m_od[i]; en = 1; end
      else if (m == 2) begin v = af_out[16*i+k]; en = af_oe[16*i+k]; end
      o[i]  = m_ot[i] ? 1'b0 : v;
      e[i]  = m_ot[i] ? (en & ~v) : en;
      pu[i] = (pl == 1);
      pd[i] = (pl == 2);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      0: return m_mode;
      1: return {16'h0, m_ot};
      2: return m_pull;
      3: return {16'h0, m_od};
      4: return {16'h0, m_id};
      5: return m_aflo;
      6: return m_afhi;
      default: return 0;
    endcase
  endfunction

  // cycle-by-cycle comparison against the model
  always begin
    @(negedge clk); #1;
    if (cmp_on && rst_n) begin
      logic [15:0] o, e, pu, pd;
      model_pads(o, e, pu, pd);
      chk(cur_req, {16'h0, pad_out}, {16'h0, o});
      chk(cur_req, {16'h0, pad_oe},  {16'h0, e});
      chk("R6", {pad_pu, pad_pd}, {pu, pd});
      chk(cur_req, bus_rdata, model_rd(bus_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #2 chk(tag, bus_rdata, exp);
  endtask

  task automatic pads(input logic [15:0] o, input logic [15:0] e, input string tag);
    @(negedge clk);
    #2;
    chk(tag, {16'h0, pad_out}, {16'h0, o});
    chk(tag, {16'h0, pad_oe},  {16'h0, e});
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    // R1 reset values
    rd(0, 32'hFFFF_FEAA, "R1");
    rd(1, 0, "R1");
    rd(2, 32'h0000_0059, "R1");
    rd(3, 0, "R1");
    rd(5, 0, "R1");
    rd(6, 0, "R1");
    pads(16'h0, 16'h0, "R1");
    chk("R6", {16'h0, pad_pu}, 32'h000D);
    chk("R6", {16'h0, pad_pd}, 32'h0002);
    // R5: analog pins read 0, debug pins sample
    rd(4, 32'h001F, "R5");

    // R4 input capture, write ignored
    cur_req = "R4";
    wr(0, 32'h0);
    pad_in = 16'hA5C3;
    @(negedge clk);
    rd(4, 32'hA5C3, "R4");
    wr(4, 32'h1234);
    rd(4, 32'hA5C3, "R4");
    pads(16'h0, 16'h0, "R5");

    // R2 push-pull output
    cur_req = "R2";
    wr(0, 32'h5555_5555);
    wr(3, 32'h3C5A);
    pads(16'h3C5A, 16'hFFFF, "R2");

    // R3 open-drain
    cur_req = "R3";
    wr(1, 32'h00FF);
    pads(16'h3C00, 16'hFFA5, "R3");

    // R8 peripherals ignored in output mode
    cur_req = "R8";
    af_out = '1; af_oe = '1;
    wr(5, 32'h7654_3210);
    wr(1, 32'h0);
    wr(3, 32'h0);
    pads(16'h0, 16'hFFFF, "R8");

    // R6 pull codes incl. reserved 11
    cur_req = "R6";
    wr(2, 32'hE4E4_E4E4);
    @(negedge clk); #2;
    chk("R6", {16'h0, pad_pu}, 32'h2222);
    chk("R6", {16'h0, pad_pd}, 32'h4444);

    // R7 alternate function routing, distinct selector per pin
    cur_req = "R7";
    af_out = '0;
    for (int i = 0; i < 16; i += 2) af_out[16*i+i] = 1'b1;
    af_out[0] = 1'b1;
    wr(6, 32'hFEDC_BA98);
    wr(0, 32'hAAAA_AAAA);
    pads(16'h5555, 16'hFFFF, "R7");
    wr(5, 32'h0);
    pads(16'h5501, 16'hFFFF, "R7");
    af_oe = '0;
    pads(16'h5501, 16'h0000, "R7");
    af_oe = '1;
    wr(1, 32'hFFFF);
    pads(16'h0, 16'hAAFE, "R7");
    wr(1, 32'h0);

    // R5 mixed input and analog
    cur_req = "R5";
    wr(0, 32'hFFFF_0000);
    pad_in = 16'hFFFF;
    @(negedge clk);
    rd(4, 32'h00FF, "R5");
    pads(16'h0, 16'h0, "R5");

    // random traffic against the model
    cur_req = "R7";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      pad_in = 16'($urandom);
      for (int w = 0; w < 8; w++) begin
        af_out[32*w +: 32] = $urandom;
        af_oe[32*w +: 32]  = $urandom;
      end
      bus_addr = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) wr(3'($urandom_range(0, 7)), $urandom);
    end

    @(negedge clk);
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule